// File: doc/BRIEF.md
# Linked-List Segment Copy Channel

This block is one copy channel that software drives through six word-wide registers. Software gives it a source address in system memory, a target address on the device side and a byte count. The channel then issues word beats on a copy port until the count runs out. The addresses step forward by one word on each accepted beat.

In chained operation the channel does not use a single segment. It reads a four-word record from system memory through a request/acknowledge read port. The record loads the two addresses, the count and a link word. The channel moves that segment and then follows the link. A flag inside the link word tells the channel to stop after the segment it has just finished.

Two flags report progress: one per finished segment and one when the whole job is over. Both are cleared by writing 1. When enabled, the job-over flag raises an interrupt line. Software can kill a running job with an abort write. An abort raises no interrupt; software sees it only through the enable bit reading 0.

Top module: `dmac_chain_channel`

## Requirements
- R1: After a synchronous reset, every register reads 0, the channel is idle, and `irq`, `desc_req` and `copy_valid` are low.
- R2: Register word indexes are 0 source address, 1 target address, 2 byte count, 3 record pointer, 4 mode, 5 control/status. `reg_rdata` returns the indexed register one cycle after `reg_idx` is presented. Mode keeps only bits 1:0: bit 0 selects chained operation and bit 1 enables the interrupt.
- R3: A write to index 5 with bit 0 (enable) and bit 1 (go) set and bit 2 clear starts an idle channel. A go write without the enable bit does nothing. Control bit 1 reads as busy.
- R4: Each beat drives the current source and target addresses and is accepted when `copy_valid` and `copy_ready` are both high. Both addresses advance by 4 and the count drops by 4, saturating at 0. A count of N bytes takes ceil(N/4) beats. Address and valid hold while the beat is not accepted.
- R5: In chained mode the channel reads words at pointer+0, +4, +8 and +12, with pointer bits 3:0 forced to 0. These words load the source address, target address, count and link word in that order, and the link word replaces the pointer register.
- R6: Bit 1 of a link word ends the job after the current segment. With bit 1 clear, the next record is read from the link address.
- R7: Control bit 4 sets after every finished segment. Control bit 3 sets when the job finishes. Writing 1 to either bit clears it, and writing 0 leaves it unchanged.
- R8: `irq` is high one cycle after bit 3 is set while mode bit 1 is 1. It falls one cycle after bit 3 is cleared. With mode bit 1 at 0 it stays low.
- R9: A segment with a byte count of 0 finishes without any beat.
- R10: Writing 1 to control bit 2 stops the channel at once and clears the enable bit. After that, no further record reads or beats occur, bit 3 is not set and `irq` is not raised.
- R11: While busy, writes to indexes 0 to 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | REG_IDX_W | Register word index for write and read |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for `reg_idx` |
| desc_req | output | 1 | Record word read request |
| desc_addr | output | DATA_W | Byte address of requested record word |
| desc_ack | input | 1 | Read accepted; `desc_data` valid this cycle |
| desc_data | input | DATA_W | Record word |
| copy_valid | output | 1 | Beat request |
| copy_ready | input | 1 | Beat accepted |
| copy_mem_addr | output | DATA_W | Source address of the beat |
| copy_dev_addr | output | DATA_W | Target address of the beat |
| irq | output | 1 | Job-finished interrupt |

## Verification
Each fault shows up at the ports within one beat or one record word.

- A wrong state in the sequencer appears as a beat or record read at an address the scoreboard did not predict.
- A miscounted segment appears as a surplus or missing beat before the done flag rises.
- A wrongly latched link word appears as a fetch from the wrong address, or from an address past the end flag.
- Status or lock faults appear on the next register read: a flag left set, the enable bit not cleared by abort, or a mode value changed while busy.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_MOVE, ST_SEG_END} eng_state_t;

  localparam int REG_MEM  = 0;
  localparam int REG_DEV  = 1;
  localparam int REG_CNT  = 2;
  localparam int REG_PTR  = 3;
  localparam int REG_MODE = 4;
  localparam int REG_CTRL = 5;

  localparam int CB_EN      = 0;
  localparam int CB_GO      = 1;
  localparam int CB_ABORT   = 2;
  localparam int CB_DONE    = 3;
  localparam int CB_SEGDONE = 4;

  localparam int MB_CHAIN = 0;
  localparam int MB_IRQEN = 1;

  localparam int NB_LAST = 1;
endpackage

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
#(
  parameter int REG_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] wr_idx,
  input  logic [4:0]           wr_bits,
  input  logic                 busy_i,
  input  logic                 seg_done_i,
  input  logic                 chain_done_i,
  output logic                 start_o,
  output logic                 abort_o,
  output logic                 enable_o,
  output logic                 done_o,
  output logic                 seg_flag_o,
  output logic [1:0]           mode_o,
  output logic                 irq_o
);
  logic ctrl_wr, mode_wr;
  logic en_q, done_q, seg_q, irq_q;
  logic [1:0] mode_q;

  assign ctrl_wr = wr_en && (wr_idx == REG_IDX_W'(REG_CTRL));
  assign mode_wr = wr_en && (wr_idx == REG_IDX_W'(REG_MODE)) && !busy_i;
  assign abort_o = ctrl_wr && wr_bits[CB_ABORT];
  assign start_o = ctrl_wr && wr_bits[CB_EN] && wr_bits[CB_GO] &&
                   !wr_bits[CB_ABORT] && !busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
      seg_q  <= 1'b0;
      irq_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      if (mode_wr) mode_q <= wr_bits[1:0];
      if (abort_o) en_q <= 1'b0;
      else if (ctrl_wr) en_q <= wr_bits[CB_EN];
      if (chain_done_i) done_q <= 1'b1;
      else if (ctrl_wr && wr_bits[CB_DONE]) done_q <= 1'b0;
      if (seg_done_i) seg_q <= 1'b1;
      else if (ctrl_wr && wr_bits[CB_SEGDONE]) seg_q <= 1'b0;
      irq_q <= done_q && mode_q[MB_IRQEN];
    end
  end

  assign enable_o   = en_q;
  assign done_o     = done_q;
  assign seg_flag_o = seg_q;
  assign mode_o     = mode_q;
  assign irq_o      = irq_q;

  // R7: job done only rises right after the engine was active
  p_done_from_active_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(busy_i));
  // R7: a job end is always also a segment end
  p_seg_with_last_r7: assert property (@(posedge clk) disable iff (rst)
    chain_done_i |-> seg_done_i);
  // R10: an abort never produces a done flag
  p_abort_no_done_r10: assert property (@(posedge clk) disable iff (rst)
    (abort_o && !done_q) |=> !done_q);
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
  import dmac_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 start_i,
  input  logic                 abort_i,
  input  logic                 chain_mode_i,
  input  logic                 desc_ack_i,
  input  logic [DATA_W-1:0]    desc_data_i,
  input  logic                 copy_ready_i,
  output logic                 busy_o,
  output logic                 seg_done_o,
  output logic                 chain_done_o,
  output logic                 desc_req_o,
  output logic [DATA_W-1:0]    desc_addr_o,
  output logic                 copy_valid_o,
  output logic [DATA_W-1:0]    copy_mem_addr_o,
  output logic [DATA_W-1:0]    copy_dev_addr_o,
  output logic [DATA_W-1:0]    cnt_o,
  output logic [DATA_W-1:0]    ptr_o
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int DESC_WORDS = 4;
  localparam int WIDX_W     = $clog2(DESC_WORDS);
  localparam int WORD_LSB   = $clog2(BEAT_BYTES);
  localparam int ALIGN_W    = WIDX_W + WORD_LSB;

  eng_state_t st_q;
  logic [WIDX_W-1:0] widx_q;
  logic [DATA_W-1:0] mem_q, dev_q, cnt_q, ptr_q;
  logic cfg_wr, last_beat, chain_end;

  assign cfg_wr    = wr_en && (st_q == ST_IDLE);
  assign last_beat = cnt_q <= DATA_W'(BEAT_BYTES);
  assign chain_end = !chain_mode_i || ptr_q[NB_LAST];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      widx_q <= '0;
      mem_q  <= '0;
      dev_q  <= '0;
      cnt_q  <= '0;
      ptr_q  <= '0;
    end else if (abort_i) begin
      st_q   <= ST_IDLE;
      widx_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (cfg_wr) begin
            if (wr_idx == REG_IDX_W'(REG_MEM)) mem_q <= wr_data;
            if (wr_idx == REG_IDX_W'(REG_DEV)) dev_q <= wr_data;
            if (wr_idx == REG_IDX_W'(REG_CNT)) cnt_q <= wr_data;
            if (wr_idx == REG_IDX_W'(REG_PTR)) ptr_q <= wr_data;
          end
          if (start_i) begin
            widx_q <= '0;
            if (chain_mode_i) st_q <= ST_FETCH;
            else st_q <= (cnt_q == '0) ? ST_SEG_END : ST_MOVE;
          end
        end
        ST_FETCH: begin
          if (desc_ack_i) begin
            case (widx_q)
              WIDX_W'(0): mem_q <= desc_data_i;
              WIDX_W'(1): dev_q <= desc_data_i;
              WIDX_W'(2): cnt_q <= desc_data_i;
              default:    ptr_q <= desc_data_i;
            endcase
            widx_q <= widx_q + WIDX_W'(1);
            if (widx_q == WIDX_W'(DESC_WORDS - 1))
              st_q <= (cnt_q == '0) ? ST_SEG_END : ST_MOVE;
          end
        end
        ST_MOVE: begin
          if (copy_ready_i) begin
            mem_q <= mem_q + DATA_W'(BEAT_BYTES);
            dev_q <= dev_q + DATA_W'(BEAT_BYTES);
            cnt_q <= last_beat ? '0 : cnt_q - DATA_W'(BEAT_BYTES);
            if (last_beat) st_q <= ST_SEG_END;
          end
        end
        default: begin
          widx_q <= '0;
          st_q   <= chain_end ? ST_IDLE : ST_FETCH;
        end
      endcase
    end
  end

  assign busy_o          = st_q != ST_IDLE;
  assign seg_done_o      = (st_q == ST_SEG_END) && !abort_i;
  assign chain_done_o    = seg_done_o && chain_end;
  assign desc_req_o      = st_q == ST_FETCH;
  assign desc_addr_o     = {ptr_q[DATA_W-1:ALIGN_W], widx_q, {WORD_LSB{1'b0}}};
  assign copy_valid_o    = st_q == ST_MOVE;
  assign copy_mem_addr_o = mem_q;
  assign copy_dev_addr_o = dev_q;
  assign cnt_o           = cnt_q;
  assign ptr_o           = ptr_q;

  // R10: abort returns the engine to idle on the next cycle
  p_abort_halts_r10: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> !busy_o);
  // R4: an accepted beat advances the source address by one word
  p_beat_step_r4: assert property (@(posedge clk) disable iff (rst)
    (copy_valid_o && copy_ready_i && !abort_i) |=>
      copy_mem_addr_o == $past(copy_mem_addr_o) + DATA_W'(BEAT_BYTES));
  // R4: a stalled beat keeps its request and addresses
  p_copy_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (copy_valid_o && !copy_ready_i && !abort_i) |=>
      copy_valid_o && $stable(copy_mem_addr_o) && $stable(copy_dev_addr_o));
  // R5: an unanswered record read holds its address
  p_fetch_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (desc_req_o && !desc_ack_i && !abort_i) |=> desc_req_o && $stable(desc_addr_o));
  // R11: software cannot move the pointer while data is moving
  p_ptr_locked_r11: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_MOVE) |=> $stable(ptr_q));
endmodule

// File: rtl/dmac_chain_channel.sv
module dmac_chain_channel
  import dmac_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_en,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 desc_req,
  output logic [DATA_W-1:0]    desc_addr,
  input  logic                 desc_ack,
  input  logic [DATA_W-1:0]    desc_data,
  output logic                 copy_valid,
  input  logic                 copy_ready,
  output logic [DATA_W-1:0]    copy_mem_addr,
  output logic [DATA_W-1:0]    copy_dev_addr,
  output logic                 irq
);
  logic start, abort, busy, seg_done, chain_done;
  logic enable, done, seg_flag;
  logic [1:0] mode;
  logic [DATA_W-1:0] cnt, ptr;

  dmac_ctrl #(.REG_IDX_W(REG_IDX_W)) ctrl_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_idx(reg_idx),
    .wr_bits(reg_wdata[4:0]), .busy_i(busy), .seg_done_i(seg_done),
    .chain_done_i(chain_done), .start_o(start), .abort_o(abort),
    .enable_o(enable), .done_o(done), .seg_flag_o(seg_flag),
    .mode_o(mode), .irq_o(irq)
  );

  dmac_engine #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)) eng_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_idx(reg_idx),
    .wr_data(reg_wdata), .start_i(start), .abort_i(abort),
    .chain_mode_i(mode[MB_CHAIN]), .desc_ack_i(desc_ack),
    .desc_data_i(desc_data), .copy_ready_i(copy_ready), .busy_o(busy),
    .seg_done_o(seg_done), .chain_done_o(chain_done), .desc_req_o(desc_req),
    .desc_addr_o(desc_addr), .copy_valid_o(copy_valid),
    .copy_mem_addr_o(copy_mem_addr), .copy_dev_addr_o(copy_dev_addr),
    .cnt_o(cnt), .ptr_o(ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_idx)
        REG_IDX_W'(REG_MEM):  reg_rdata <= copy_mem_addr;
        REG_IDX_W'(REG_DEV):  reg_rdata <= copy_dev_addr;
        REG_IDX_W'(REG_CNT):  reg_rdata <= cnt;
        REG_IDX_W'(REG_PTR):  reg_rdata <= ptr;
        REG_IDX_W'(REG_MODE): reg_rdata <= DATA_W'(mode);
        REG_IDX_W'(REG_CTRL): reg_rdata <= DATA_W'({seg_flag, done, 1'b0, busy, enable});
        default:              reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: tb/dmac_chain_channel_tb_top.sv
module dmac_chain_channel_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [2:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic desc_req, desc_ack = 1'b0;
  logic [31:0] desc_addr, desc_data = '0;
  logic copy_valid, copy_ready = 1'b0;
  logic [31:0] copy_mem_addr, copy_dev_addr;
  logic irq;

  dmac_chain_channel dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .desc_req(desc_req),
    .desc_addr(desc_addr), .desc_ack(desc_ack), .desc_data(desc_data),
    .copy_valid(copy_valid), .copy_ready(copy_ready),
    .copy_mem_addr(copy_mem_addr), .copy_dev_addr(copy_dev_addr), .irq(irq)
  );

  int checks = 0, errors = 0;
  int beats_seen = 0, fetch_seen = 0, cyc = 0;
  logic [31:0] dmem [0:127];
  logic [31:0] bmem_q[$], bdev_q[$], fetch_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stimulus for the read and copy ports, one step after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      desc_ack   = desc_req && (cyc % 3 != 0);
      desc_data  = dmem[desc_addr[8:2]];
      copy_ready = (cyc % 4 != 1);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (copy_valid && copy_ready) begin
        beats_seen++;
        if (bmem_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 unexpected beat actual=%h expected=none", copy_mem_addr);
        end else begin
          check("R4 beat source", copy_mem_addr, bmem_q.pop_front());
          check("R4 beat target", copy_dev_addr, bdev_q.pop_front());
        end
      end
      if (desc_req && desc_ack) begin
        fetch_seen++;
        if (fetch_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6 unexpected record read actual=%h expected=none", desc_addr);
        end else check("R5 record address", desc_addr, fetch_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    reg_idx = idx;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic exp_run(input logic [31:0] m, input logic [31:0] dv, input int n);
    for (int i = 0; i < (n + 3) / 4; i++) begin
      bmem_q.push_back(m + 32'(4 * i));
      bdev_q.push_back(dv + 32'(4 * i));
    end
  endtask

  task automatic exp_fetch(input logic [31:0] p);
    for (int i = 0; i < 4; i++) fetch_q.push_back(p + 32'(4 * i));
  endtask

  task automatic put_desc(input int a, input logic [31:0] m, input logic [31:0] dv,
                          input logic [31:0] n, input logic [31:0] nx);
    dmem[a / 4] = m; dmem[a / 4 + 1] = dv; dmem[a / 4 + 2] = n; dmem[a / 4 + 3] = nx;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd5, v);
      if (v[1] == 1'b0) return;
    end
    checks++; errors++;
    $display("FAIL %s channel stuck busy actual=1 expected=0", req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int b0, f0;
    for (int i = 0; i < 128; i++) dmem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int i = 0; i < 6; i++) begin rd(3'(i), v); check("R1 reset register", v, 32'h0); end
    check("R1 irq", 32'(irq), 0);
    check("R1 desc_req", 32'(desc_req), 0);
    check("R1 copy_valid", 32'(copy_valid), 0);

    // R2 register map
    wr(3'd0, 32'h1000); wr(3'd1, 32'h8000); wr(3'd2, 32'd10); wr(3'd3, 32'h1234_5670);
    wr(3'd4, 32'hFF);
    rd(3'd0, v); check("R2 source reg", v, 32'h1000);
    rd(3'd1, v); check("R2 target reg", v, 32'h8000);
    rd(3'd2, v); check("R2 count reg", v, 32'd10);
    rd(3'd3, v); check("R2 pointer reg", v, 32'h1234_5670);
    rd(3'd4, v); check("R2 mode keeps two bits", v, 32'h3);
    wr(3'd4, 32'h0);

    // R3 go without enable does nothing
    b0 = beats_seen;
    wr(3'd5, 32'h2);
    rd(3'd5, v); check("R3 go without enable", v, 32'h0);
    check("R3 no beats", 32'(beats_seen), 32'(b0));

    // R3 R4 single segment of 10 bytes
    exp_run(32'h1000, 32'h8000, 10);
    wr(3'd5, 32'h3);
    rd(3'd5, v); check("R3 busy after start", v, 32'h3);
    wait_idle("R4");
    check("R4 all beats seen", 32'(bmem_q.size()), 0);
    rd(3'd0, v); check("R4 source advanced", v, 32'h100C);
    rd(3'd1, v); check("R4 target advanced", v, 32'h800C);
    rd(3'd2, v); check("R4 count spent", v, 32'h0);
    rd(3'd5, v); check("R7 flags after job", v, 32'h19);
    check("R8 irq off when disabled", 32'(irq), 0);

    // R7 write-one-to-clear
    wr(3'd5, 32'h09);
    rd(3'd5, v); check("R7 clear done only", v, 32'h11);
    wr(3'd5, 32'h11);
    rd(3'd5, v); check("R7 clear segment flag", v, 32'h01);

    // R9 zero count single, R8 irq
    wr(3'd4, 32'h2); wr(3'd2, 32'h0);
    b0 = beats_seen;
    wr(3'd5, 32'h3);
    wait_idle("R9");
    check("R9 zero count no beats", 32'(beats_seen), 32'(b0));
    rd(3'd5, v); check("R9 zero count completes", v, 32'h19);
    check("R8 irq raised", 32'(irq), 1);
    wr(3'd5, 32'h19);
    @(negedge clk);
    check("R8 irq drops after clear", 32'(irq), 0);

    // R5 R6 R9 R11 chained job of three records
    put_desc(32'h40, 32'h2000, 32'h9000, 32'd8, 32'h80);
    put_desc(32'h80, 32'h3000, 32'hA000, 32'd0, 32'hC0);
    put_desc(32'hC0, 32'h4004, 32'hB000, 32'd5, 32'h102);
    wr(3'd4, 32'h3); wr(3'd3, 32'h40);
    exp_fetch(32'h40); exp_fetch(32'h80); exp_fetch(32'hC0);
    exp_run(32'h2000, 32'h9000, 8);
    exp_run(32'h4004, 32'hB000, 5);
    f0 = fetch_seen;
    wr(3'd5, 32'h3);
    wr(3'd4, 32'h0);
    wait_idle("R5");
    check("R5 record reads done", 32'(fetch_q.size()), 0);
    check("R6 stops at end flag", 32'(fetch_seen - f0), 12);
    check("R5 all beats seen", 32'(bmem_q.size()), 0);
    rd(3'd4, v); check("R11 mode locked while busy", v, 32'h3);
    rd(3'd3, v); check("R6 last link in pointer", v, 32'h102);
    rd(3'd0, v); check("R5 source from last record", v, 32'h400C);
    rd(3'd1, v); check("R5 target from last record", v, 32'hB008);
    rd(3'd5, v); check("R7 flags after chain", v, 32'h19);
    check("R8 irq after chain", 32'(irq), 1);
    wr(3'd5, 32'h18);
    @(negedge clk);

    // R10 abort in the middle of a long segment
    put_desc(32'h140, 32'h5000, 32'hC000, 32'd64, 32'h2);
    wr(3'd3, 32'h140);
    exp_fetch(32'h140);
    exp_run(32'h5000, 32'hC000, 64);
    wr(3'd5, 32'h3);
    repeat (8) @(negedge clk);
    wr(3'd5, 32'h4);
    b0 = beats_seen; f0 = fetch_seen;
    rd(3'd5, v); check("R10 enable cleared, idle, no done", v, 32'h0);
    repeat (20) @(negedge clk);
    check("R10 no beats after abort", 32'(beats_seen), 32'(b0));
    check("R10 no reads after abort", 32'(fetch_seen), 32'(f0));
    check("R10 no irq", 32'(irq), 0);
    check("R10 copy_valid low", 32'(copy_valid), 0);
    bmem_q.delete(); bdev_q.delete(); fetch_q.delete();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule